// File: doc/BRIEF.md
# 8-bit ALU with nibble flags

A purely combinational arithmetic unit for an 8-bit accumulator processor. Each evaluation takes an operation code, two byte operands, two 16-bit operands, a signed byte offset and the current flag nibble. It returns a byte result, a 16-bit result, the next value of each of the four flags (zero Z, subtract N, half-carry H, carry C), and one write-enable per flag. A flag whose enable is low is echoed unchanged from the input, so the surrounding core may either use the enables or take the flag outputs directly.

The byte path covers increment, decrement, add, add-with-carry, subtract and subtract-with-borrow. The half-carry always reflects the carry (or borrow) between bit 3 and bit 4, with the incoming carry included where the operation consumes it. The wide path covers a 16-bit register-pair add, whose half-carry comes from bit 11, and a stack-pointer plus signed-offset add, whose H and C come only from the low-byte addition. The register file, decoding and memory are outside this block.

Top module: `alu8_core`

## Requirements
- R1: Flags are packed as Z at bit 3, N at bit 2, H at bit 1 and C at bit 0 on `flags_i`, `flags_o` and `flag_we_o`; any flag whose enable is 0 leaves `flags_o` equal to the same bit of `flags_i`, and the result port not used by an operation equals its pass-through operand (`res8_o` = `a_i`, `res16_o` = `wa_i`).
- R2: Code 0 (increment): `res8_o` = `a_i`+1 mod 256; Z set when that is zero, N cleared, H set when the low nibble of `a_i` is 0xF; C not written (enables 1110).
- R3: Code 1 (decrement): `res8_o` = `a_i`−1 mod 256; Z set when zero, N set, H set when the low nibble of `a_i` is 0x0; C not written (enables 1110).
- R4: Code 2 (add): `res8_o` = `a_i`+`b_i` mod 256; N cleared, C set when the full sum exceeds 0xFF, H set when the low nibbles sum above 0xF, Z on zero; all four written.
- R5: Code 3 (add with carry): as R4 with the incoming C added; H set when lowA+lowB+C > 0xF and C set when A+B+C > 0xFF.
- R6: Code 4 (subtract): `res8_o` = `a_i`−`b_i` mod 256; N set, C set when A < B, H set when lowA < lowB, Z on zero; all written.
- R7: Code 5 (subtract with borrow): `res8_o` = A−B−Cin mod 256; N set, C set when A < B+Cin, H set when lowA < lowB+Cin, Z on zero; all written.
- R8: Code 6 (wide add): `res16_o` = `wa_i`+`wb_i` mod 65536; N cleared, H set on carry out of bit 11, C on carry out of bit 15; Z not written (enables 0111).
- R9: Code 7 (stack pointer plus offset): `res16_o` = `wa_i` + sign-extended `ofs_i` mod 65536; Z and N forced to 0, H from carry out of bit 3 and C from carry out of bit 7 of the unsigned low-byte sum `wa_i[7:0]`+`ofs_i`; all written.
- R10: Codes 8 to 15 write no flag (enables 0000), pass `a_i` to `res8_o` and `wa_i` to `res16_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 7 defined, rest idle) |
| a_i | input | 8 | Byte operand A (accumulator) |
| b_i | input | 8 | Byte operand B |
| wa_i | input | 16 | Wide operand A, or stack pointer for code 7 |
| wb_i | input | 16 | Wide operand B for code 6 |
| ofs_i | input | 8 | Signed offset for code 7 |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| res8_o | output | 8 | Byte result |
| res16_o | output | 16 | Wide result |
| flags_o | output | 4 | Next flags {Z,N,H,C} |
| flag_we_o | output | 4 | Per-flag write enables {Z,N,H,C} |

## Verification
Every byte operation is driven with all 65,536 operand pairs under both carry-in values, so nibble boundaries (0x0F/0x10, 0xFF/0x00) and the carry-in folded into H and C are all exercised against an arithmetic model written from the requirements. The wide add sweeps operand pairs whose bit-11 and bit-15 carries occur independently, which separates a correct bit-11 half-carry from one taken at bit 3 or bit 7. The offset add crosses all 256 offsets with stack-pointer values whose low bytes straddle carries, distinguishing low-byte H/C from flags of the full 16-bit sum and catching a missing sign extension. Hand-computed table rows and directed cases pin the idle codes and the echo of unwritten flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_INC  = 4'd0,
      OP_DEC  = 4'd1,
      OP_ADD  = 4'd2,
      OP_ADC  = 4'd3,
      OP_SUB  = 4'd4,
      OP_SBC  = 4'd5,
      OP_ADDW = 4'd6,
      OP_SPOF = 4'd7
   } alu_op_e;

   localparam int FLAG_W = 4;
   localparam int OP_W   = 4;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   localparam flags_t WE_NONE  = flags_t'(4'b0000);
   localparam flags_t WE_ALL   = flags_t'(4'b1111);
   localparam flags_t WE_NO_C  = flags_t'(4'b1110);
   localparam flags_t WE_NO_Z  = flags_t'(4'b0111);

endpackage

// File: rtl/alu8_nib_add.sv
module alu8_nib_add #(
   parameter int W         = 8,
   parameter int SPLIT_AT  = 4,
   parameter bit CHAIN_ADD = 1'b1
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         c_mid,
   output logic         c_out
);

   localparam int HI_W = W - SPLIT_AT;

   if (SPLIT_AT < 1 || SPLIT_AT >= W) begin : g_bad_split
      $error("alu8_nib_add: SPLIT_AT must lie inside the word");
   end

   if (CHAIN_ADD) begin : g_chain
      logic [SPLIT_AT:0] lo;
      logic [HI_W:0]     hi;

      assign lo = {1'b0, x[SPLIT_AT-1:0]} + {1'b0, y[SPLIT_AT-1:0]}
                + {{SPLIT_AT{1'b0}}, cin};
      assign hi = {1'b0, x[W-1:SPLIT_AT]} + {1'b0, y[W-1:SPLIT_AT]}
                + {{HI_W{1'b0}}, lo[SPLIT_AT]};

      assign sum   = {hi[HI_W-1:0], lo[SPLIT_AT-1:0]};
      assign c_mid = lo[SPLIT_AT];
      assign c_out = hi[HI_W];
   end else begin : g_flat
      logic [W:0] full;

      assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      assign sum   = full[W-1:0];
      assign c_out = full[W];
      // carry into the split bit recovered from the sum bit parity
      assign c_mid = x[SPLIT_AT] ^ y[SPLIT_AT] ^ full[SPLIT_AT];
   end

endmodule

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
   import alu8_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit CHAIN_ADD = 1'b1
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   output logic [DW-1:0] res,
   output flags_t        fl,
   output flags_t        we,
   output logic          hit
);

   localparam int NW = DW / 2;

   logic [DW-1:0] y;
   logic          ci;
   logic          h_inv;
   logic          c_inv;
   logic          n_val;
   logic [DW-1:0] sum;
   logic          c_mid;
   logic          c_out;

   always_comb begin
      y     = '0;
      ci    = 1'b0;
      h_inv = 1'b0;
      c_inv = 1'b0;
      n_val = 1'b0;
      we    = WE_NONE;
      hit   = 1'b1;
      case (op)
         OP_INC: begin
            ci = 1'b1;
            we = WE_NO_C;
         end
         OP_DEC: begin
            y     = '1;
            h_inv = 1'b1;
            c_inv = 1'b1;
            n_val = 1'b1;
            we    = WE_NO_C;
         end
         OP_ADD: begin
            y  = b;
            we = WE_ALL;
         end
         OP_ADC: begin
            y  = b;
            ci = cin;
            we = WE_ALL;
         end
         OP_SUB: begin
            y     = ~b;
            ci    = 1'b1;
            h_inv = 1'b1;
            c_inv = 1'b1;
            n_val = 1'b1;
            we    = WE_ALL;
         end
         OP_SBC: begin
            y     = ~b;
            ci    = ~cin;
            h_inv = 1'b1;
            c_inv = 1'b1;
            n_val = 1'b1;
            we    = WE_ALL;
         end
         default: hit = 1'b0;
      endcase
   end

   alu8_nib_add #(
      .W         (DW),
      .SPLIT_AT  (NW),
      .CHAIN_ADD (CHAIN_ADD)
   ) u_add (
      .x     (a),
      .y     (y),
      .cin   (ci),
      .sum   (sum),
      .c_mid (c_mid),
      .c_out (c_out)
   );

   assign res  = sum;
   assign fl.z = (sum == '0);
   assign fl.n = n_val;
   assign fl.h = c_mid ^ h_inv;
   assign fl.c = c_out ^ c_inv;

endmodule

// File: rtl/alu8_wide_unit.sv
module alu8_wide_unit
   import alu8_pkg::*;
#(
   parameter int DW        = 8,
   parameter int WW        = 16,
   parameter bit CHAIN_ADD = 1'b1
) (
   input  alu_op_e       op,
   input  logic [WW-1:0] wa,
   input  logic [WW-1:0] wb,
   input  logic [DW-1:0] ofs,
   output logic [WW-1:0] res,
   output flags_t        fl,
   output flags_t        we,
   output logic          hit
);

   localparam int NW     = DW / 2;
   localparam int WSPLIT = WW - NW;
   localparam int EXT_W  = WW - DW;

   logic [WW-1:0]    w_sum;
   logic             w_mid;
   logic             w_out;
   logic [DW-1:0]    lo_sum;
   logic             lo_mid;
   logic             lo_out;
   logic [EXT_W-1:0] hi_sum;

   alu8_nib_add #(
      .W         (WW),
      .SPLIT_AT  (WSPLIT),
      .CHAIN_ADD (CHAIN_ADD)
   ) u_wide_add (
      .x     (wa),
      .y     (wb),
      .cin   (1'b0),
      .sum   (w_sum),
      .c_mid (w_mid),
      .c_out (w_out)
   );

   alu8_nib_add #(
      .W         (DW),
      .SPLIT_AT  (NW),
      .CHAIN_ADD (CHAIN_ADD)
   ) u_low_add (
      .x     (wa[DW-1:0]),
      .y     (ofs),
      .cin   (1'b0),
      .sum   (lo_sum),
      .c_mid (lo_mid),
      .c_out (lo_out)
   );

   // upper part: sign extension of the offset plus the low-byte carry
   assign hi_sum = wa[WW-1:DW] + {EXT_W{ofs[DW-1]}} + {{(EXT_W-1){1'b0}}, lo_out};

   always_comb begin
      res = wa;
      fl  = flags_t'(4'b0000);
      we  = WE_NONE;
      hit = 1'b1;
      case (op)
         OP_ADDW: begin
            res  = w_sum;
            fl.h = w_mid;
            fl.c = w_out;
            we   = WE_NO_Z;
         end
         OP_SPOF: begin
            res  = {hi_sum, lo_sum};
            fl.h = lo_mid;
            fl.c = lo_out;
            we   = WE_ALL;
         end
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int WIDE_W    = 16,
   parameter bit CHAIN_ADD = 1'b1
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [WIDE_W-1:0] wa_i,
   input  logic [WIDE_W-1:0] wb_i,
   input  logic [DATA_W-1:0] ofs_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] res8_o,
   output logic [WIDE_W-1:0] res16_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic [FLAG_W-1:0] flag_we_o
);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("alu8_core: DATA_W must be even and at least 4");
   end
   if (WIDE_W != 2 * DATA_W) begin : g_bad_wide_w
      $error("alu8_core: WIDE_W must be twice DATA_W");
   end

   alu_op_e             op;
   logic [DATA_W-1:0]   b_res;
   flags_t              b_fl;
   flags_t              b_we;
   logic                b_hit;
   logic [WIDE_W-1:0]   w_res;
   flags_t              w_fl;
   flags_t              w_we;
   logic                w_hit;
   flags_t              sel_fl;
   flags_t              sel_we;

   assign op = alu_op_e'(op_i);

   alu8_byte_unit #(
      .DW        (DATA_W),
      .CHAIN_ADD (CHAIN_ADD)
   ) u_byte (
      .op  (op),
      .a   (a_i),
      .b   (b_i),
      .cin (flags_i[0]),
      .res (b_res),
      .fl  (b_fl),
      .we  (b_we),
      .hit (b_hit)
   );

   alu8_wide_unit #(
      .DW        (DATA_W),
      .WW        (WIDE_W),
      .CHAIN_ADD (CHAIN_ADD)
   ) u_wide (
      .op  (op),
      .wa  (wa_i),
      .wb  (wb_i),
      .ofs (ofs_i),
      .res (w_res),
      .fl  (w_fl),
      .we  (w_we),
      .hit (w_hit)
   );

   always_comb begin
      if (b_hit) begin
         sel_fl = b_fl;
         sel_we = b_we;
      end else if (w_hit) begin
         sel_fl = w_fl;
         sel_we = w_we;
      end else begin
         sel_fl = flags_t'(4'b0000);
         sel_we = WE_NONE;
      end
   end

   assign res8_o    = b_hit ? b_res : a_i;
   assign res16_o   = w_hit ? w_res : wa_i;
   assign flag_we_o = sel_we;
   assign flags_o   = (sel_we & sel_fl) | (~sel_we & flags_i);

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WIDE_W = 16
) (
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [WIDE_W-1:0] wa_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [DATA_W-1:0] res8_o,
   input logic [WIDE_W-1:0] res16_o,
   input logic [FLAG_W-1:0] flags_o,
   input logic [FLAG_W-1:0] flag_we_o
);

   logic is_byte;
   logic is_wide;
   logic is_idle;

   assign is_byte = (op_i <= 4'd5);
   assign is_wide = (op_i == 4'd6) || (op_i == 4'd7);
   assign is_idle = !is_byte && !is_wide;

   always_comb begin
      AST_UNWRITTEN_ECHO:
         assert ((~flag_we_o & flags_o) == (~flag_we_o & flags_i)) else $error("unwritten flag moved"); // R1
      AST_PASS_THROUGH:
         assert ((is_byte || res8_o == a_i) && (is_wide || res16_o == wa_i)) else $error("unused result moved"); // R1
      AST_STEP_KEEPS_C:
         assert (!(op_i == 4'd0 || op_i == 4'd1) || flag_we_o == 4'b1110) else $error("step enables"); // R2
      AST_STEP_ZERO:
         assert (!(op_i == 4'd0 || op_i == 4'd1) || flags_o[3] == (res8_o == '0)) else $error("step zero"); // R3
      AST_SUBTRACT_N_SET:
         assert (!(op_i == 4'd1 || op_i == 4'd4 || op_i == 4'd5) || flags_o[2]) else $error("N not set"); // R6
      AST_ADD_N_CLEAR:
         assert (!(op_i == 4'd0 || op_i == 4'd2 || op_i == 4'd3 || is_wide) || !flags_o[2]) else $error("N not clear"); // R4
      AST_WIDE_KEEPS_Z:
         assert (op_i != 4'd6 || flag_we_o == 4'b0111) else $error("wide add enables"); // R8
      AST_OFFSET_Z_CLEAR:
         assert (op_i != 4'd7 || (flag_we_o == 4'b1111 && !flags_o[3])) else $error("offset add Z"); // R9
      AST_IDLE_NO_WRITE:
         assert (!is_idle || flag_we_o == 4'b0000) else $error("idle code wrote flags"); // R10
   end

endmodule

bind alu8_core alu8_core_chk #(
   .DATA_W (DATA_W),
   .WIDE_W (WIDE_W)
) u_chk (
   .op_i      (op_i),
   .a_i       (a_i),
   .wa_i      (wa_i),
   .flags_i   (flags_i),
   .res8_o    (res8_o),
   .res16_o   (res16_o),
   .flags_o   (flags_o),
   .flag_we_o (flag_we_o)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/100ps
module alu8_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk;
   logic [3:0]  op;
   logic [7:0]  a, b, ofs;
   logic [15:0] wa, wb;
   logic [3:0]  fin;
   logic [7:0]  res8;
   logic [15:0] res16;
   logic [3:0]  fout, fwe;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   alu8_core u_dut (
      .op_i      (op),
      .a_i       (a),
      .b_i       (b),
      .wa_i      (wa),
      .wb_i      (wb),
      .ofs_i     (ofs),
      .flags_i   (fin),
      .res8_o    (res8),
      .res16_o   (res16),
      .flags_o   (fout),
      .flag_we_o (fwe)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles == WATCHDOG) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1: run hung, actual %0d cycles expected fewer", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // {op, a, b, cin, exp res8, exp flags, exp enables}; flags in = {0,0,0,cin}
   localparam int NV = 12;
   localparam logic [36:0] VEC [NV] = '{
      {4'd0,  8'h0F, 8'h00, 1'b1, 8'h10, 4'b0011, 4'b1110},  // R2 nibble carry, C echoed
      {4'd0,  8'hFF, 8'h00, 1'b0, 8'h00, 4'b1010, 4'b1110},  // R2 wrap
      {4'd1,  8'h10, 8'h00, 1'b0, 8'h0F, 4'b0110, 4'b1110},  // R3 nibble borrow
      {4'd1,  8'h01, 8'h00, 1'b1, 8'h00, 4'b1101, 4'b1110},  // R3 zero
      {4'd2,  8'h3A, 8'hC6, 1'b1, 8'h00, 4'b1011, 4'b1111},  // R4 carry ignores Cin
      {4'd3,  8'hE1, 8'h0E, 1'b1, 8'hF0, 4'b0010, 4'b1111},  // R5 Cin makes H
      {4'd3,  8'hFF, 8'h00, 1'b1, 8'h00, 4'b1011, 4'b1111},  // R5 Cin makes C
      {4'd4,  8'h3E, 8'h3E, 1'b0, 8'h00, 4'b1100, 4'b1111},  // R6 equal
      {4'd4,  8'h10, 8'h01, 1'b1, 8'h0F, 4'b0110, 4'b1111},  // R6 half borrow
      {4'd5,  8'h3B, 8'h2A, 1'b1, 8'h10, 4'b0100, 4'b1111},  // R7 no borrow
      {4'd5,  8'h00, 8'hFF, 1'b1, 8'h00, 4'b1111, 4'b1111},  // R7 borrow with Cin
      {4'd15, 8'h5A, 8'hA5, 1'b1, 8'h5A, 4'b0001, 4'b0000}   // R10 idle
   };

   function automatic logic [31:0] ref_byte(int o, int x, int y, logic [3:0] f);
      int  c, r;
      logic z, n, h, cc;
      logic [3:0] we;
      c = f[0];
      z = f[3]; n = f[2]; h = f[1]; cc = f[0]; r = x; we = 4'b0000;
      case (o)
         0: begin r = (x + 1) & 255; n = 0; h = (x & 15) == 15; we = 4'b1110; end
         1: begin r = (x - 1) & 255; n = 1; h = (x & 15) == 0;  we = 4'b1110; end
         2: begin r = (x + y) & 255; n = 0; h = (x & 15) + (y & 15) > 15;
                  cc = (x + y) > 255; we = 4'b1111; end
         3: begin r = (x + y + c) & 255; n = 0; h = (x & 15) + (y & 15) + c > 15;
                  cc = (x + y + c) > 255; we = 4'b1111; end
         4: begin r = (x - y) & 255; n = 1; h = (x & 15) < (y & 15);
                  cc = x < y; we = 4'b1111; end
         5: begin r = (x - y - c) & 255; n = 1; h = (x & 15) < (y & 15) + c;
                  cc = x < y + c; we = 4'b1111; end
         default: ;
      endcase
      if (we[3]) z = (r == 0);
      return {wa, r[7:0], z, n, h, cc, we};
   endfunction

   function automatic logic [31:0] ref_wide(int o, int p, int q, int s, logic [3:0] f);
      int r, so;
      logic h, cc;
      if (o == 6) begin
         r  = (p + q) & 65535;
         h  = (p & 12'hFFF) + (q & 12'hFFF) > 12'hFFF;
         cc = (p + q) > 65535;
         return {r[15:0], a, f[3], 1'b0, h, cc, 4'b0111};
      end
      so = (s >= 128) ? s - 256 : s;
      r  = (p + so) & 65535;
      h  = (p & 15) + (s & 15) > 15;
      cc = (p & 255) + s > 255;
      return {r[15:0], a, 1'b0, 1'b0, h, cc, 4'b1111};
   endfunction

   task automatic drive(int o, int x, int y, int p, int q, int s, logic [3:0] f);
      op = 4'(o); a = 8'(x); b = 8'(y); wa = 16'(p); wb = 16'(q); ofs = 8'(s); fin = f;
      #0.4;
   endtask

   task automatic check(string tag, logic [31:0] exp);
      logic [31:0] act;
      act = {res16, res8, fout, fwe};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (op %0d a %h b %h wa %h wb %h ofs %h f %b)",
                  tag, act, exp, op, a, b, wa, wb, ofs, fin);
      end
      #0.6;
   endtask

   initial begin
      #2.0;
      // idle state with all-zero inputs: R10 and R1
      drive(15, 0, 0, 0, 0, 0, 4'b0000);
      check("R10 quiet state", 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(int'(VEC[i][36:33]), int'(VEC[i][32:25]), int'(VEC[i][24:17]),
               16'h1234, 16'h0, 0, {3'b000, VEC[i][16]});
         check($sformatf("R%0d table row %0d", (VEC[i][36:33] > 7) ? 10 : VEC[i][36:33] + 2, i),
               {16'h1234, VEC[i][15:0]});
      end

      // wide directed corners
      drive(6, 8'h77, 0, 16'h0FFF, 16'h0001, 0, 4'b1000);
      check("R8 bit11 carry, Z echoed", {16'h1000, 8'h77, 4'b1010, 4'b0111});
      drive(6, 8'h77, 0, 16'hFFFF, 16'h0001, 0, 4'b0100);
      check("R8 bit15 carry", {16'h0000, 8'h77, 4'b0011, 4'b0111});
      drive(7, 8'h11, 0, 16'hFFF8, 0, 8'h08, 4'b1100);
      check("R9 low byte carries", {16'h0000, 8'h11, 4'b0011, 4'b1111});
      drive(7, 8'h11, 0, 16'h0000, 0, 8'hFF, 4'b1111);
      check("R9 negative offset", {16'hFFFF, 8'h11, 4'b0000, 4'b1111});
      drive(7, 8'h11, 0, 16'h00FF, 0, 8'h01, 4'b0000);
      check("R9 carry into high byte", {16'h0100, 8'h11, 4'b0011, 4'b1111});
      drive(9, 8'hC3, 8'h3C, 16'hBEEF, 16'h1111, 8'h80, 4'b1010);
      check("R10 idle echoes flags R1", {16'hBEEF, 8'hC3, 4'b1010, 4'b0000});

      // exhaustive byte operations, both carry-in values
      for (int o = 0; o < 6; o++) begin
         for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 256; x++) begin
               for (int y = 0; y < 256; y++) begin
                  logic [3:0] f;
                  f = {c[0], ~c[0], c[0], c[0]};
                  drive(o, x, y, 16'hA55A, 0, 0, f);
                  check($sformatf("R%0d sweep", o + 2), ref_byte(o, x, y, f));
               end
            end
         end
      end

      // wide add sweep
      for (int i = 0; i < 64; i++) begin
         for (int j = 0; j < 64; j++) begin
            int p, q;
            p = (i * 1031) & 65535;
            q = (j * 977 + 4095) & 65535;
            drive(6, 8'h3C, 0, p, q, 0, {i[0], 3'b101});
            check("R8 sweep", ref_wide(6, p, q, 0, {i[0], 3'b101}));
         end
      end

      // offset add sweep
      for (int k = 0; k < 16; k++) begin
         for (int s = 0; s < 256; s++) begin
            int p;
            p = (k * 4099 + 240) & 65535;
            drive(7, 8'hC3, 0, p, 0, s, 4'b1111);
            check("R9 sweep", ref_wide(7, p, 0, s, 4'b1111));
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule